// File: doc/BRIEF.md
# Memory Type Range Lookup Unit

This unit answers one question per request: which cache memory type applies to a given physical address. It holds the type configuration on chip. That configuration is a bank of 88 fixed-range type bytes that covers the first megabyte, a parameterised number of variable ranges (each a base register and a mask register), a default-type register, and an optional top-of-memory limit. Above 4 GiB and below that limit, every address is write-back.

A request is accepted only while the unit is idle. An address in the first megabyte, with fixed ranges enabled, is answered from the fixed bank in the cycle after acceptance. Any other address is compared against the variable ranges, one range per clock. Overlapping matches are merged by a precedence rule. Uncached takes priority and ends the scan early. The answer is a type byte qualified by a one-cycle valid pulse. Configuration is loaded through a simple write port, selected by a register kind and an index.

Top module: `mtype_lookup`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the response. `rsp_valid` is high for exactly one cycle. `req_ready` returns to 1 in the cycle after the response.
- R3: The answer is 0xFF (invalid) in the cycle after acceptance in two cases. The first is when no default-type register write has happened since reset. The second is when the global enable, bit 11 of the default-type register, is 0.
- R4: The fixed-bank path answers in the cycle after acceptance, with byte k of the fixed bank. The index k depends on the address range:
  - below 0x80000, k = addr>>16;
  - from 0x80000 to 0xBFFFF, k = 8 + ((addr-0x80000)>>14);
  - from 0xC0000 to 0xFFFFF, k = 24 + ((addr-0xC0000)>>12).
- R5: The fixed-bank path is used only when all three conditions hold: the address is below 0x100000, the fixed enable (bit 10 of the default-type register) is 1, and the global enable is 1. Otherwise the address takes the variable-range path.
- R6: A variable range takes part only when bit 11 of its mask register is 1. It matches when (addr & mask) equals (base & mask), with bits 11:0 of base, mask and address ignored. Its type is bits 7:0 of its base register.
- R7: The variable path examines range 0 first and one range per clock. Without an early stop, the response is visible N clock edges after the accepting edge, where N is the number of variable ranges.
- R8: Types are encoded as uncached 0x00, write-combining 0x01, write-through 0x04, write-protect 0x05, write-back 0x06. The first matching range sets the result. Each later match is merged with the running result, in this order of precedence:
  - If either type is uncached, the result is uncached and the scan stops.
  - A write-back and write-through pair gives write-through.
  - Any other pair of different types gives uncached and stops the scan.

  A stop at range k makes the response visible k+1 edges after acceptance.
- R9: When no variable range matches, the answer is bits 7:0 of the default-type register.
- R10: The top-of-memory register keeps only bits 47:23 of the written value. On the variable path, the answer is forced to 0x06 when three conditions hold: the stored value is nonzero, the address is at least 2^32, and the address is below the stored value. This override also applies after an early stop.
- R11: The write port takes `wr_kind` and `wr_idx`:
  - `wr_kind` 0 writes fixed byte `wr_idx`;
  - `wr_kind` 1 writes variable base `wr_idx`;
  - `wr_kind` 2 writes variable mask `wr_idx`;
  - `wr_kind` 3 with index 0 writes the default-type register;
  - `wr_kind` 3 with index 1 writes the top-of-memory register.

  A write whose index is out of range for its kind changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_kind | input | 2 | Register kind being written |
| wr_idx | input | 7 | Register index within the kind |
| wr_data | input | 64 | Write data |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_addr | input | ADDR_W | Physical address to classify |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_type | output | 8 | Resulting memory type |

## Verification
The bench builds the unit with four variable ranges, a 48-bit address, and both the fixed bank and the top-of-memory override present. Four ranges are enough to produce early stops at the second and third positions, full-length scans, and merges of three overlapping ranges, all in short runs. The widest address leaves room to test the bit 47:23 truncation of the top-of-memory value, and to test both sides of the 4 GiB boundary.

// File: rtl/mtl_pkg.sv
package mtl_pkg;

   localparam logic [7:0] MT_UC      = 8'h00;
   localparam logic [7:0] MT_WC      = 8'h01;
   localparam logic [7:0] MT_WT      = 8'h04;
   localparam logic [7:0] MT_WP      = 8'h05;
   localparam logic [7:0] MT_WB      = 8'h06;
   localparam logic [7:0] MT_INVALID = 8'hFF;

   localparam int FIXED_BYTES = 88;

   localparam logic [1:0] WK_FIXED = 2'd0;
   localparam logic [1:0] WK_BASE  = 2'd1;
   localparam logic [1:0] WK_MASK  = 2'd2;
   localparam logic [1:0] WK_CTRL  = 2'd3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_DONE = 2'd2
   } lookup_state_t;

endpackage

// File: rtl/mtl_fixed_bank.sv
module mtl_fixed_bank
   import mtl_pkg::*;
#(
   parameter bit HAS_FIXED = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [6:0]  wr_idx,
   input  logic [7:0]  wr_byte,
   input  logic [19:0] look_addr,
   output logic [7:0]  look_type
);

   generate
      if (HAS_FIXED) begin : g_bank
         logic [7:0] mem_q [FIXED_BYTES];
         logic [6:0] rd_idx;
         logic       unused_lo;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < FIXED_BYTES; i++) mem_q[i] <= '0;
            end else if (wr_en && (wr_idx < 7'(FIXED_BYTES))) begin
               mem_q[wr_idx] <= wr_byte;
            end
         end

         always_comb begin
            if (!look_addr[19])
               rd_idx = {4'b0, look_addr[18:16]};
            else if (!look_addr[18])
               rd_idx = 7'd8 + {3'b0, look_addr[17:14]};
            else
               rd_idx = 7'd24 + {1'b0, look_addr[17:12]};
         end

         assign look_type = mem_q[rd_idx];
         assign unused_lo = ^look_addr[11:0];
      end else begin : g_none
         logic unused_fix;
         assign look_type  = MT_UC;
         assign unused_fix = ^{clk, rst_n, wr_en, wr_idx, wr_byte, look_addr};
      end
   endgenerate

endmodule

// File: rtl/mtl_var_bank.sv
module mtl_var_bank #(
   parameter int NUM_VAR = 8,
   parameter int ADDR_W  = 48,
   parameter int IDX_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_base_en,
   input  logic              wr_mask_en,
   input  logic [6:0]        wr_idx,
   input  logic [63:0]       wr_data,
   input  logic [IDX_W-1:0]  sel,
   input  logic [ADDR_W-1:0] look_addr,
   output logic              hit,
   output logic [7:0]        hit_type
);

   localparam int PG_W = ADDR_W - 12;

   logic [PG_W-1:0] base_a [NUM_VAR];
   logic [PG_W-1:0] mask_a [NUM_VAR];
   logic [7:0]      type_a [NUM_VAR];
   logic            vld_a  [NUM_VAR];
   logic            unused_bits;

   genvar g;
   generate
      for (g = 0; g < NUM_VAR; g++) begin : g_rng
         logic [PG_W-1:0] base_r;
         logic [PG_W-1:0] mask_r;
         logic [7:0]      type_r;
         logic            vld_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               base_r <= '0;
               mask_r <= '0;
               type_r <= '0;
               vld_r  <= 1'b0;
            end else begin
               if (wr_base_en && (wr_idx == 7'(g))) begin
                  base_r <= wr_data[ADDR_W-1:12];
                  type_r <= wr_data[7:0];
               end
               if (wr_mask_en && (wr_idx == 7'(g))) begin
                  mask_r <= wr_data[ADDR_W-1:12];
                  vld_r  <= wr_data[11];
               end
            end
         end

         assign base_a[g] = base_r;
         assign mask_a[g] = mask_r;
         assign type_a[g] = type_r;
         assign vld_a[g]  = vld_r;
      end
   endgenerate

   assign hit = vld_a[sel] &&
                (((look_addr[ADDR_W-1:12] ^ base_a[sel]) & mask_a[sel]) == '0);
   assign hit_type = type_a[sel];

   assign unused_bits = ^{wr_data[63:ADDR_W], wr_data[10:8], look_addr[11:0]};

endmodule

// File: rtl/mtl_merge.sv
module mtl_merge
   import mtl_pkg::*;
(
   input  logic       prev_vld,
   input  logic [7:0] prev_type,
   input  logic       cur_hit,
   input  logic [7:0] cur_type,
   output logic       nxt_vld,
   output logic [7:0] nxt_type,
   output logic       stop
);

   always_comb begin
      nxt_vld  = prev_vld;
      nxt_type = prev_type;
      stop     = 1'b0;
      if (cur_hit) begin
         nxt_vld = 1'b1;
         if (!prev_vld) begin
            nxt_type = cur_type;
         end else if ((prev_type == MT_UC) || (cur_type == MT_UC)) begin
            nxt_type = MT_UC;
            stop     = 1'b1;
         end else if (((prev_type == MT_WB) && (cur_type == MT_WT)) ||
                      ((prev_type == MT_WT) && (cur_type == MT_WB))) begin
            nxt_type = MT_WT;
         end else if (prev_type != cur_type) begin
            nxt_type = MT_UC;
            stop     = 1'b1;
         end
      end
   end

endmodule

// File: rtl/mtype_lookup.sv
module mtype_lookup
   import mtl_pkg::*;
#(
   parameter int ADDR_W    = 48,
   parameter int NUM_VAR   = 8,
   parameter bit HAS_FIXED = 1'b1,
   parameter bit HAS_TOP2  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_kind,
   input  logic [6:0]        wr_idx,
   input  logic [63:0]       wr_data,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic [7:0]        rsp_type
);

   localparam int IDX_W = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1;
   localparam int T2_W  = ADDR_W - 23;

   generate
      if ((ADDR_W < 33) || (ADDR_W > 48)) begin : g_bad_aw
         $error("mtype_lookup: ADDR_W must lie in 33..48");
      end
      if ((NUM_VAR < 1) || (NUM_VAR > 64)) begin : g_bad_nv
         $error("mtype_lookup: NUM_VAR must lie in 1..64");
      end
   endgenerate

   lookup_state_t     state_q;
   logic [IDX_W-1:0]  scan_idx;
   logic [ADDR_W-1:0] cap_addr;
   logic              acc_vld;
   logic [7:0]        acc_type;
   logic [7:0]        res_type;

   logic [7:0] def_type;
   logic       en_gen, en_fix, cfg_loaded;
   logic       top2_hit;

   logic       wr_ctrl;
   assign wr_ctrl = wr_en && (wr_kind == WK_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         def_type   <= '0;
         en_gen     <= 1'b0;
         en_fix     <= 1'b0;
         cfg_loaded <= 1'b0;
      end else if (wr_ctrl && (wr_idx == 7'd0)) begin
         def_type   <= wr_data[7:0];
         en_fix     <= wr_data[10];
         en_gen     <= wr_data[11];
         cfg_loaded <= 1'b1;
      end
   end

   generate
      if (HAS_TOP2) begin : g_top2
         logic [T2_W-1:0] top2_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               top2_q <= '0;
            else if (wr_ctrl && (wr_idx == 7'd1))
               top2_q <= wr_data[ADDR_W-1:23];
         end
         assign top2_hit = (top2_q != '0) && (cap_addr[ADDR_W-1:32] != '0) &&
                           (cap_addr < {top2_q, 23'b0});
      end else begin : g_no_top2
         assign top2_hit = 1'b0;
      end
   endgenerate

   logic [7:0] fix_type;
   mtl_fixed_bank #(.HAS_FIXED(HAS_FIXED)) u_fixed (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en && (wr_kind == WK_FIXED)),
      .wr_idx    (wr_idx),
      .wr_byte   (wr_data[7:0]),
      .look_addr (req_addr[19:0]),
      .look_type (fix_type)
   );

   logic       var_hit;
   logic [7:0] var_type;
   mtl_var_bank #(.NUM_VAR(NUM_VAR), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_var (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_base_en (wr_en && (wr_kind == WK_BASE)),
      .wr_mask_en (wr_en && (wr_kind == WK_MASK)),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .sel        (scan_idx),
      .look_addr  (cap_addr),
      .hit        (var_hit),
      .hit_type   (var_type)
   );

   logic       nxt_vld, stop;
   logic [7:0] nxt_type;
   mtl_merge u_merge (
      .prev_vld  (acc_vld),
      .prev_type (acc_type),
      .cur_hit   (var_hit),
      .cur_type  (var_type),
      .nxt_vld   (nxt_vld),
      .nxt_type  (nxt_type),
      .stop      (stop)
   );

   logic accept, fixed_path, last_rng;
   assign accept     = req_valid && (state_q == ST_IDLE);
   assign fixed_path = HAS_FIXED && en_fix && (req_addr[ADDR_W-1:20] == '0);
   assign last_rng   = (scan_idx == IDX_W'(NUM_VAR - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         scan_idx <= '0;
         cap_addr <= '0;
         acc_vld  <= 1'b0;
         acc_type <= '0;
         res_type <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               cap_addr <= req_addr;
               scan_idx <= '0;
               acc_vld  <= 1'b0;
               if (!cfg_loaded || !en_gen) begin
                  res_type <= MT_INVALID;
                  state_q  <= ST_DONE;
               end else if (fixed_path) begin
                  res_type <= fix_type;
                  state_q  <= ST_DONE;
               end else begin
                  state_q  <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               acc_vld  <= nxt_vld;
               acc_type <= nxt_type;
               if (stop || last_rng) begin
                  state_q <= ST_DONE;
                  if (top2_hit)
                     res_type <= MT_WB;
                  else if (nxt_vld)
                     res_type <= nxt_type;
                  else
                     res_type <= def_type;
               end else begin
                  scan_idx <= scan_idx + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign rsp_valid = (state_q == ST_DONE);
   assign rsp_type  = res_type;

endmodule

module mtl_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       rsp_valid,
   input logic [7:0] rsp_type,
   input logic       cfg_loaded,
   input logic       en_gen,
   input logic       top2_hit
);

   // R2: response strobe lasts one cycle
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R2: unit is busy right after taking a request
   a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R2: unit is idle again after the response
   a_r2_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> req_ready);

   // R3: unloaded or globally disabled gives invalid
   a_r3_invalid_type: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (!cfg_loaded || !en_gen)) |-> (rsp_type == 8'hFF));

   // R10: top-of-memory window forces write-back
   a_r10_top2_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && cfg_loaded && en_gen && top2_hit) |-> (rsp_type == 8'h06));

endmodule

bind mtype_lookup mtl_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .rsp_type   (rsp_type),
   .cfg_loaded (cfg_loaded),
   .en_gen     (en_gen),
   .top2_hit   (top2_hit)
);

// File: tb/mtype_lookup_bench.sv
`timescale 1ns/1ps
module mtype_lookup_bench;

   localparam int AW = 48;
   localparam int NV = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_kind = '0;
   logic [6:0]    wr_idx = '0;
   logic [63:0]   wr_data = '0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid;
   logic [7:0]    rsp_type;

   always #2 clk = ~clk;

   mtype_lookup #(.ADDR_W(AW), .NUM_VAR(NV)) u_mtype_lookup (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
      .wr_idx(wr_idx), .wr_data(wr_data), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
      .rsp_type(rsp_type));

   int checks = 0;
   int errors = 0;

   // reference configuration
   logic [7:0]  m_fix [88];
   logic [63:0] m_base [NV];
   logic [63:0] m_mask [NV];
   logic [63:0] m_def = '0;
   logic        m_loaded = 1'b0;
   logic [63:0] m_top2 = '0;

   localparam logic [63:0] PGM = 64'h0000_FFFF_FFFF_F000;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act %h exp %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] msk(input logic [63:0] size, input bit vld);
      return (~(size - 64'd1) & PGM) | (vld ? 64'h800 : 64'h0);
   endfunction

   task automatic wr(input logic [1:0] k, input int idx, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_kind = k; wr_idx = 7'(idx); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      case (k)
         2'd0: if (idx < 88) m_fix[idx] = d[7:0];
         2'd1: if (idx < NV) m_base[idx] = d;
         2'd2: if (idx < NV) m_mask[idx] = d;
         default: begin
            if (idx == 0) begin m_def = d; m_loaded = 1'b1; end
            if (idx == 1) m_top2 = d & 64'h0000_FFFF_FF80_0000;
         end
      endcase
   endtask

   task automatic model(input logic [63:0] a, output logic [7:0] t, output int lat);
      logic pv;
      logic [7:0] p, c;
      int k;
      if (!m_loaded || !m_def[11]) begin
         t = 8'hFF; lat = 0;
      end else if ((a < 64'h100000) && m_def[10]) begin
         if (a < 64'h80000) k = int'(a >> 16);
         else if (a < 64'hC0000) k = 8 + int'((a - 64'h80000) >> 14);
         else k = 24 + int'((a - 64'hC0000) >> 12);
         t = m_fix[k]; lat = 0;
      end else begin
         pv = 1'b0; p = 8'h00; lat = NV;
         for (int i = 0; i < NV; i++) begin
            if (m_mask[i][11] && (((a ^ m_base[i]) & m_mask[i] & PGM) == 64'd0)) begin
               c = m_base[i][7:0];
               if (!pv) begin
                  pv = 1'b1; p = c;
               end else if (p == 8'h00 || c == 8'h00 || (p != c &&
                        !((p == 8'h06 && c == 8'h04) || (p == 8'h04 && c == 8'h06)))) begin
                  p = 8'h00; lat = i + 1; break;
               end else if (p != c) begin
                  p = 8'h04;
               end
            end
         end
         t = pv ? p : m_def[7:0];
         if (m_top2 != 0 && a >= 64'h1_0000_0000 && a < m_top2) t = 8'h06;
      end
   endtask

   task automatic lookup(input logic [63:0] a, input string tag);
      logic [7:0] et;
      int lat;
      model(a, et, lat);
      @(negedge clk);
      chk({tag, "/R2 ready before"}, {7'b0, req_ready}, 8'd1);
      req_valid = 1'b1; req_addr = a[AW-1:0];
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int n = 0; n <= lat + 1; n++) begin
         if (n > 0) @(negedge clk);
         chk({tag, "/R2 ready"}, {7'b0, req_ready}, {7'b0, (n > lat)});
         chk({tag, "/R7 valid timing"}, {7'b0, rsp_valid}, {7'b0, (n == lat)});
         if (n == lat) chk({tag, " type"}, rsp_type, et);
      end
   endtask

   initial begin
      for (int i = 0; i < 88; i++) m_fix[i] = '0;
      for (int i = 0; i < NV; i++) begin m_base[i] = '0; m_mask[i] = '0; end
      repeat (3) @(negedge clk);
      chk("R1 rsp_valid", {7'b0, rsp_valid}, 8'd0);
      chk("R1 req_ready", {7'b0, req_ready}, 8'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {7'b0, rsp_valid}, 8'd0);

      lookup(64'h1000, "R3 unloaded");
      wr(2'd3, 0, 64'h006);
      lookup(64'h2000, "R3 disabled");

      for (int i = 0; i < 88; i++) wr(2'd0, i, 64'((i * 37 + 3) & 8'hFF));
      wr(2'd3, 0, 64'hC00);
      lookup(64'h00000, "R4 64K lo");
      lookup(64'h7FFFF, "R4 64K hi");
      lookup(64'h45678, "R4 64K mid");
      lookup(64'h80000, "R4 16K lo");
      lookup(64'hBC000, "R4 16K hi");
      lookup(64'hC0000, "R4 4K lo");
      lookup(64'hFF000, "R4 4K hi");
      lookup(64'hFFFFF, "R4 4K top");

      wr(2'd3, 0, 64'h806);
      lookup(64'h12345, "R5 fixed off");
      wr(2'd3, 0, 64'hC05);
      lookup(64'h100000, "R5 above 1M");

      wr(2'd1, 0, 64'h1_0000_0000 | 64'h06);
      wr(2'd2, 0, msk(64'h4000_0000, 1'b1));
      lookup(64'h1_2345_6789, "R6 single hit");
      lookup(64'h1_4000_0000, "R9 no match");

      wr(2'd1, 1, 64'h1_0000_0000 | 64'h04);
      wr(2'd2, 1, msk(64'h1000_0000, 1'b1));
      lookup(64'h1_0000_1000, "R8 wb+wt");

      wr(2'd1, 2, 64'h1_0000_0000 | 64'h01);
      wr(2'd2, 2, msk(64'h0400_0000, 1'b1));
      lookup(64'h1_0000_2000, "R8 wt+wc stop");
      lookup(64'h1_2000_0000, "R7 one of three");

      wr(2'd1, 0, 64'h1_0000_0000 | 64'h00);
      lookup(64'h1_0000_0000, "R8 uc first stop");

      wr(2'd1, 3, 64'h5_0000_0F01);
      wr(2'd2, 3, msk(64'h1000, 1'b0));
      lookup(64'h5_0000_0000, "R6 valid clear");
      wr(2'd2, 3, msk(64'h1000, 1'b1) | 64'h7FF);
      lookup(64'h5_0000_0ABC, "R6 low bits ignored");

      wr(2'd1, 4, 64'h5_0000_0000);
      wr(2'd2, 4, msk(64'h1_0000_0000, 1'b1));
      lookup(64'h5_0000_0000, "R11 var idx out of range");
      wr(2'd3, 0, 64'hC05);
      wr(2'd0, 100, 64'h77);
      lookup(64'hFF000, "R11 fixed idx out of range");

      wr(2'd3, 0, 64'h805);
      wr(2'd3, 1, 64'h3_0000_0000 | 64'h40_0000);
      lookup(64'h1_0000_0000, "R10 override after stop");
      lookup(64'h2_FFFF_F000, "R10 override default");
      lookup(64'h3_0000_1000, "R10 truncated limit");
      lookup(64'h8000_0000, "R10 below 4G");

      wr(2'd3, 0, 64'h406);
      lookup(64'h1_0000_0000, "R3 global off");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act hung exp done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule